// File: doc/BRIEF.md
# Flash Command and Status Register Front End

This block is the register-level front end of an on-chip flash controller. A bus master reaches three 32-bit registers through a simple write port and a combinational read port: a key register, a control register and a status register. The control register starts out locked. It only accepts writes after the key register has received a fixed pair of words in the right order. Once unlocked, software can start three operations: a sector erase, a mass erase of either bank or both, or a program request. Each operation runs on an internal countdown that stands in for the real array timing. The status busy flag stays high for as long as the countdown runs.

Program requests arrive on a valid/ready stream that carries the target address. A request is accepted on a cycle where both `prog_valid` and `prog_ready` are high. `prog_ready` is low whenever an operation is running, so the master must hold the request stable until it is taken.

Every accepted operation produces a one-cycle `op_start` pulse toward the array, with its kind, sector index, bank mask and address. Illegal requests launch nothing. Instead they set sticky error flags, which software clears by writing ones. While any flag is pending, the engine refuses new work.

Top module: `flash_cmd_regs`

## Requirements
- R1: After reset, the control register reads 0x8000_0000 (lock, bit 31, set; all fields zero), the status register reads 0, and `prog_ready` is high.
- R2: The control register unlocks only after two key-register writes (register select 0): first 0x4567_0123, then 0xCDEF_89AB. A wrong value or a wrong order leaves it locked. Control writes while locked change no field.
- R3: A key-register write while unlocked relocks the control register and clears its fields.
- R4: A control write with bit 31 set relocks immediately; the control register then reads 0x8000_0000.
- R5: The control register (select 1) holds program at bit 0, sector erase at bit 1, bank-one mass erase at bit 2, sector code at bits 7:3, program width at bits 9:8, and bank-two mass erase at bit 15. These fields read back as written. Start (bit 16) is a command and always reads 0.
- R6: Sector codes 0..11 select sectors 0..11. Codes 0x10|k (k = 0..11) select sector 12+k. Any other code sets the operation error (status bit 1), and no operation starts.
- R7: A single control write with sector erase, a valid code and start launches one sector erase. Busy stays high for exactly SECTOR_CYC cycles.
- R8: A start with bit 2 and/or bit 15 set (and sector erase clear) launches a mass erase with bank mask {bit15, bit2}. Busy stays high for MASS_CYC cycles.
- R9: A start while locked, while busy, while any error flag is pending, with no operation selected, or with sector erase and mass erase together sets the sequence error (status bit 7) and launches nothing.
- R10: A program request taken while the program bit is clear or the block is locked sets the sequence error. An address misaligned to the width (0 = byte, 1 = 2-byte, 2 = 4-byte, 3 = 8-byte) sets the alignment error (status bit 5). Otherwise the request launches a program that keeps busy high for PROG_CYC cycles, and `prog_ready` stays low throughout.
- R11: Writing the status register (select 2) clears exactly the error bits written as one; all other flags stay set.
- R12: Status bit 16 reads 1 from the cycle after a launch until the countdown ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 key, 1 control, 2 status |
| reg_wdata | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding |
| rd_data | output | 32 | Combinational read data |
| prog_valid | input | 1 | Program request valid |
| prog_ready | output | 1 | Program request ready (low while busy) |
| prog_addr | input | ADDR_W | Program target byte address |
| op_start | output | 1 | One-cycle launch pulse to the array |
| op_kind | output | 2 | 1 sector erase, 2 mass erase, 3 program |
| op_sector | output | 5 | Linear sector index of a sector erase |
| op_banks | output | 2 | Mass erase bank mask {bank two, bank one} |
| op_addr | output | ADDR_W | Address of a program launch |

## Verification
The bench builds the block with SECTOR_CYC = 20, MASS_CYC = 40, PROG_CYC = 5 and ADDR_W = 16. These values keep every countdown short enough to measure edge to edge. They also leave a start-while-busy attempt a wide window inside a sector erase. Because the three durations differ, a launch that loads the wrong duration shows up as a wrong busy length. The 16-bit address still covers all three alignment masks.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [31:0] UNLOCK_KEY_A = 32'h4567_0123;
  localparam logic [31:0] UNLOCK_KEY_B = 32'hCDEF_89AB;

  // control field positions (decoded by software)
  localparam int CR_PG     = 0;
  localparam int CR_SER    = 1;
  localparam int CR_MER1   = 2;
  localparam int CR_SNB_LO = 3;
  localparam int CR_SNB_W  = 5;
  localparam int CR_PSZ_LO = 8;
  localparam int CR_MER2   = 15;
  localparam int CR_GO     = 16;
  localparam int CR_LOCK   = 31;

  // status field positions
  localparam int SR_BUSY  = 16;
  localparam int SR_SEQ   = 7;
  localparam int SR_ALIGN = 5;
  localparam int SR_OPER  = 1;

  typedef enum logic [1:0] {
    OPK_NONE   = 2'd0,
    OPK_SECTOR = 2'd1,
    OPK_MASS   = 2'd2,
    OPK_PROG   = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    RS_KEY  = 2'd0,
    RS_CTRL = 2'd1,
    RS_STAT = 2'd2,
    RS_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic seq;
    logic align;
    logic oper;
  } err_t;
endpackage

// File: rtl/fcs_keyguard.sv
module fcs_keyguard
  import fcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        unlocked
);
  typedef enum logic [1:0] {KG_SHUT, KG_HALF, KG_OPEN} kg_state_e;
  kg_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      KG_SHUT: if (key_wr) st_d = (key_data == UNLOCK_KEY_A) ? KG_HALF : KG_SHUT;
      KG_HALF: if (key_wr) st_d = (key_data == UNLOCK_KEY_B) ? KG_OPEN : KG_SHUT;
      KG_OPEN: if (key_wr || relock) st_d = KG_SHUT;
      default: st_d = KG_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= KG_SHUT;
    else        st_q <= st_d;

  assign unlocked = (st_q == KG_OPEN);

  // R2: opening only ever follows a second-key write
  assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && key_data == UNLOCK_KEY_B));
  // R3: a key write while open always closes
  assert_rekey_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_wr) |=> !unlocked);
endmodule

// File: rtl/fcs_sector_map.sv
module fcs_sector_map #(
  parameter int CODE_W        = 5,
  parameter int SECT_PER_BANK = 12,
  localparam int IDX_W        = CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic              valid,
  output logic [IDX_W-1:0]  index
);
  logic [CODE_W-2:0] local_num;
  logic              bank_two;

  assign bank_two  = code[CODE_W-1];
  assign local_num = code[CODE_W-2:0];
  assign valid     = (int'(local_num) < SECT_PER_BANK);
  assign index     = bank_two ? IDX_W'(int'(local_num) + SECT_PER_BANK)
                              : IDX_W'(local_num);
endmodule

// File: rtl/fcs_op_timer.sv
module fcs_op_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt_q <= '0;
    else if (load)      cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;

  assign busy = (cnt_q != 0);

  // R9: the engine never reloads a running countdown
  assert_no_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  // R7: busy ends only from the last count
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt_q) == 1);
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int SECTOR_CYC = 2000,
  parameter int MASS_CYC   = 20000,
  parameter int PROG_CYC   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  input  logic              prog_valid,
  output logic              prog_ready,
  input  logic [ADDR_W-1:0] prog_addr,
  output logic              op_start,
  output logic [1:0]        op_kind,
  output logic [4:0]        op_sector,
  output logic [1:0]        op_banks,
  output logic [ADDR_W-1:0] op_addr
);
  localparam int MAX_CYC = (MASS_CYC > SECTOR_CYC) ?
                           ((MASS_CYC > PROG_CYC) ? MASS_CYC : PROG_CYC) :
                           ((SECTOR_CYC > PROG_CYC) ? SECTOR_CYC : PROG_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  // register decode
  logic key_wr, ctrl_wr, stat_wr, unlocked, busy;
  assign key_wr  = reg_wr && (reg_sel_e'(reg_sel) == RS_KEY);
  assign ctrl_wr = reg_wr && (reg_sel_e'(reg_sel) == RS_CTRL);
  assign stat_wr = reg_wr && (reg_sel_e'(reg_sel) == RS_STAT);

  logic relock_req;
  assign relock_req = ctrl_wr && unlocked && reg_wdata[CR_LOCK];

  fcs_keyguard u_keyguard (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (reg_wdata),
    .relock   (relock_req),
    .unlocked (unlocked)
  );

  // control fields
  logic                pg_q, ser_q, mer1_q, mer2_q;
  logic [CR_SNB_W-1:0] snb_q;
  logic [1:0]          psz_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {pg_q, ser_q, mer1_q, mer2_q} <= '0;
      snb_q <= '0;
      psz_q <= '0;
    end else if (relock_req || (key_wr && unlocked)) begin
      {pg_q, ser_q, mer1_q, mer2_q} <= '0;
      snb_q <= '0;
      psz_q <= '0;
    end else if (ctrl_wr && unlocked) begin
      pg_q   <= reg_wdata[CR_PG];
      ser_q  <= reg_wdata[CR_SER];
      mer1_q <= reg_wdata[CR_MER1];
      mer2_q <= reg_wdata[CR_MER2];
      snb_q  <= reg_wdata[CR_SNB_LO +: CR_SNB_W];
      psz_q  <= reg_wdata[CR_PSZ_LO +: 2];
    end

  // start command evaluation (uses the word being written)
  err_t err_q, err_set, err_clr;
  logic errs_pending;
  assign errs_pending = |err_q;

  logic w_ser, w_mer_any, start_req, start_legal;
  assign w_ser     = reg_wdata[CR_SER];
  assign w_mer_any = reg_wdata[CR_MER1] | reg_wdata[CR_MER2];
  assign start_req = ctrl_wr && reg_wdata[CR_GO];
  assign start_legal = unlocked && !reg_wdata[CR_LOCK] && !busy && !errs_pending &&
                       (w_ser ^ w_mer_any);

  logic       sect_valid;
  logic [4:0] sect_index;
  fcs_sector_map #(.CODE_W(CR_SNB_W), .SECT_PER_BANK(12)) u_map (
    .code  (reg_wdata[CR_SNB_LO +: CR_SNB_W]),
    .valid (sect_valid),
    .index (sect_index)
  );

  logic launch_sect, launch_mass, bad_sector;
  assign launch_sect = start_req && start_legal && w_ser && sect_valid;
  assign bad_sector  = start_req && start_legal && w_ser && !sect_valid;
  assign launch_mass = start_req && start_legal && !w_ser;

  // program request stream
  logic prog_fire, prog_legal, misalign, launch_prog;
  assign prog_ready = !busy;
  assign prog_fire  = prog_valid && prog_ready;
  assign prog_legal = unlocked && pg_q && !errs_pending && !start_req;

  always_comb begin
    unique case (psz_q)
      2'd0:    misalign = 1'b0;
      2'd1:    misalign = prog_addr[0];
      2'd2:    misalign = |prog_addr[1:0];
      default: misalign = |prog_addr[2:0];
    endcase
  end

  assign launch_prog = prog_fire && prog_legal && !misalign;

  // sticky error flags, write one to clear, set wins
  assign err_set.seq   = (start_req && !start_legal) || (prog_fire && !prog_legal);
  assign err_set.align = prog_fire && prog_legal && misalign;
  assign err_set.oper  = bad_sector;
  assign err_clr.seq   = stat_wr && reg_wdata[SR_SEQ];
  assign err_clr.align = stat_wr && reg_wdata[SR_ALIGN];
  assign err_clr.oper  = stat_wr && reg_wdata[SR_OPER];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err_q <= '0;
    else        err_q <= (err_q & ~err_clr) | err_set;

  // operation countdown
  logic             launch_any;
  logic [CNT_W-1:0] load_val;
  assign launch_any = launch_sect || launch_mass || launch_prog;
  assign load_val   = launch_sect ? CNT_W'(SECTOR_CYC) :
                      launch_mass ? CNT_W'(MASS_CYC)   : CNT_W'(PROG_CYC);

  fcs_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch_any),
    .load_val (load_val),
    .busy     (busy)
  );

  // launch report toward the array
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op_start  <= 1'b0;
      op_kind   <= OPK_NONE;
      op_sector <= '0;
      op_banks  <= '0;
      op_addr   <= '0;
    end else begin
      op_start <= launch_any;
      if (launch_sect) begin
        op_kind   <= OPK_SECTOR;
        op_sector <= sect_index;
        op_banks  <= '0;
      end else if (launch_mass) begin
        op_kind   <= OPK_MASS;
        op_sector <= '0;
        op_banks  <= {reg_wdata[CR_MER2], reg_wdata[CR_MER1]};
      end else if (launch_prog) begin
        op_kind   <= OPK_PROG;
        op_sector <= '0;
        op_banks  <= '0;
        op_addr   <= prog_addr;
      end
    end

  // read port
  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      RS_CTRL: rd_data = {!unlocked, 15'b0, mer2_q, 5'b0, psz_q, snb_q, mer1_q, ser_q, pg_q};
      RS_STAT: rd_data = {15'b0, busy, 8'b0, err_q.seq, 1'b0, err_q.align, 1'b0, 2'b0,
                          err_q.oper, 1'b0};
      default: rd_data = 32'h0;
    endcase
  end

  // R12: a launch pulse always coincides with the countdown running
  assert_launch_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> busy);
  // R9: nothing is launched from a locked state
  assert_no_locked_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(unlocked));
  // R11: flags drop only on a status write
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((err_q & $past(err_q)) == $past(err_q)));
  // R10: a program request is never taken while busy
  assert_no_take_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && busy) |=> !(op_start && op_kind == OPK_PROG && $past(!busy) == 1'b0));
endmodule

// File: tb/flash_cmd_regs_test.sv
module flash_cmd_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int SEC_N = 20, MASS_N = 40, PROG_N = 5;

  logic          clk = 0, rst_n = 0;
  logic          reg_wr = 0;
  logic [1:0]    reg_sel = 0, rd_sel = 0;
  logic [31:0]   reg_wdata = 0, rd_data;
  logic          prog_valid = 0, prog_ready;
  logic [AW-1:0] prog_addr = 0, op_addr;
  logic          op_start;
  logic [1:0]    op_kind, op_banks;
  logic [4:0]    op_sector;

  flash_cmd_regs #(.ADDR_W(AW), .SECTOR_CYC(SEC_N), .MASS_CYC(MASS_N), .PROG_CYC(PROG_N)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .op_start(op_start), .op_kind(op_kind), .op_sector(op_sector),
    .op_banks(op_banks), .op_addr(op_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];   // {kind, sector, banks, addr} packed per launch

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_op(input logic [1:0] k, input logic [4:0] s,
                                          input logic [1:0] b, input logic [AW-1:0] a);
    return {7'b0, k, s, b, a};
  endfunction

  // monitor: compares every launch with the expected queue
  always @(negedge clk) if (rst_n && op_start) begin
    if (exp_q.size() == 0) chk("R9 unexpected launch", pack_op(op_kind, op_sector, op_banks, op_addr), 32'h0);
    else chk("R6/R7/R8/R10 launch", pack_op(op_kind, op_sector, op_banks, op_addr), exp_q.pop_front());
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_sel = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_sel = a; #1; d = rd_data;
  endtask

  task automatic prog(input logic [AW-1:0] a);
    while (!prog_ready) @(negedge clk);
    prog_valid = 1; prog_addr = a;
    @(negedge clk);
    prog_valid = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!prog_ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic unlock();
    wr(0, 32'h4567_0123); wr(0, 32'hCDEF_89AB);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(1, v); chk("R1 ctrl reset", v, 32'h8000_0000);
    rd(2, v); chk("R1 status reset", v, 32'h0);
    chk("R1 ready", prog_ready, 1);
    // R2 locked writes and bad keys
    wr(1, 32'h0000_8229); rd(1, v); chk("R2 locked write ignored", v, 32'h8000_0000);
    wr(0, 32'h4567_0123); wr(0, 32'h1234_5678); rd(1, v); chk("R2 wrong second key", v, 32'h8000_0000);
    wr(0, 32'hCDEF_89AB); rd(1, v); chk("R2 second key alone", v, 32'h8000_0000);
    unlock(); rd(1, v); chk("R2 unlocked", v, 32'h0);
    // R5 field readback
    wr(1, 32'h0000_8229); rd(1, v); chk("R5 readback", v, 32'h0000_8229);
    // R9 no operation selected, start reads 0
    wr(1, 32'h0001_0000); rd(1, v); chk("R5 start not stored", v, 32'h0);
    rd(2, v); chk("R9 no-op start", v, 32'h80);
    // R9 errors pending block a start
    wr(1, 32'h0001_001A); rd(2, v); chk("R9 error pending", v, 32'h80);
    wr(2, 32'h80); rd(2, v); chk("R11 clear", v, 32'h0);
    // R7 sector erase sector 3
    exp_q.push_back(pack_op(2'd1, 5'd3, 2'd0, '0));
    wr(1, 32'h0001_001A); rd(2, v); chk("R12 busy bit", v, 32'h0001_0000);
    busy_len(n); chk("R7 sector duration", n, SEC_N);
    // R6 bank-two sector 14
    exp_q.push_back(pack_op(2'd1, 5'd14, 2'd0, '0));
    wr(1, 32'h0001_0092); busy_len(n); chk("R6 bank two duration", n, SEC_N);
    // R6 invalid code 12
    wr(1, 32'h0001_0062); rd(2, v); chk("R6 invalid code", v, 32'h2);
    wr(2, 32'h2); rd(2, v); chk("R11 clear oper", v, 32'h0);
    // R9 start while busy
    exp_q.push_back(pack_op(2'd1, 5'd0, 2'd0, '0));
    wr(1, 32'h0001_0002); wr(1, 32'h0001_0002);
    rd(2, v); chk("R9 start while busy", v, 32'h0001_0080);
    busy_len(n); wr(2, 32'h80);
    // R9 sector and mass together
    wr(1, 32'h0001_0006); rd(2, v); chk("R9 mixed ops", v, 32'h80);
    wr(2, 32'h80);
    // R8 mass erase bank one, then both
    wr(1, 32'h4);
    exp_q.push_back(pack_op(2'd2, 5'd0, 2'd1, '0));
    wr(1, 32'h0001_0004); busy_len(n); chk("R8 mass duration", n, MASS_N);
    wr(1, 32'h8004);
    exp_q.push_back(pack_op(2'd2, 5'd0, 2'd3, '0));
    wr(1, 32'h0001_8004); busy_len(n); chk("R8 both banks duration", n, MASS_N);
    // R10 program alignment
    wr(1, 32'h101);
    prog(16'h0011); rd(2, v); chk("R10 misaligned 16-bit", v, 32'h20);
    wr(2, 32'h20);
    exp_q.push_back(pack_op(2'd3, 5'd0, 2'd0, 16'h0010));
    prog(16'h0010); chk("R10 ready low", prog_ready, 0);
    busy_len(n); chk("R10 program duration", n, PROG_N);
    wr(1, 32'h301); prog(16'h0014); rd(2, v); chk("R10 misaligned 64-bit", v, 32'h20);
    wr(2, 32'h20);
    wr(1, 32'h001);
    exp_q.push_back(pack_op(2'd3, 5'd0, 2'd0, 16'h0013));
    prog(16'h0013); busy_len(n); chk("R10 byte program", n, PROG_N);
    // R10 program bit clear
    wr(1, 32'h0); prog(16'h0020); rd(2, v); chk("R10 pg clear", v, 32'h80);
    // R11 partial clear
    wr(1, 32'h201); prog(16'h0001); rd(2, v); chk("R10 seq and align", v, 32'h80);
    wr(2, 32'h80); wr(1, 32'h201); prog(16'h0001);
    wr(1, 32'h0); prog(16'h0);
    rd(2, v); chk("R11 both set", v, 32'hA0);
    wr(2, 32'h80); rd(2, v); chk("R11 partial clear", v, 32'h20);
    wr(2, 32'h20);
    // R4 relock by bit 31
    wr(1, 32'h8229); wr(1, 32'h8000_0000); rd(1, v); chk("R4 relock", v, 32'h8000_0000);
    wr(1, 32'h0001_001A); rd(2, v); chk("R9 start while locked", v, 32'h80);
    wr(2, 32'h80);
    // R3 key write while unlocked
    unlock(); wr(1, 32'h8229); wr(0, 32'h4567_0123);
    rd(1, v); chk("R3 rekey relocks", v, 32'h8000_0000);
    repeat (3) @(negedge clk);
    chk("R7 all launches seen", exp_q.size(), 0);
    summary();
  end
endmodule